// File: doc/BRIEF.md
# Single-Level Page Map Translator

This block turns a virtual address into a physical address by looking up a page map held on chip. The map has one entry for every virtual page, and the virtual page number comes from the high bits of the address. Each entry stores three things: a resident flag, a modified (dirty) flag and a physical page number. When the page is resident, the block returns the physical page number followed by the untouched page offset. When it is not resident, the block raises a fault and returns no address.

Two complete maps are kept, one for the kernel and one for the user. A mode input chooses between them. The processor drives that input high when it takes an interrupt and low again on interrupt return. Because of this, switching context costs no reload.

A software fault handler fills in entries through a write port. Each write loads one entry per cycle into the map named by its own context input. A store that hits a resident page sets that entry's dirty flag, so the replacement path can tell whether the page must be written back.

The default parameters give a small map so that it is cheap to elaborate. Raising the widths gives the full 20-bit virtual page number and 18-bit physical page number of a 32-bit address space with 1 GB of memory.

Top module: `page_map_xlate`

## Requirements
- R1: Reset clears the resident flag of every entry in both maps, and holds all four outputs at 0.
- R2: `rsp_valid` is 1 in exactly the cycle after a cycle with `req_valid` at 1. The response is registered, so it appears one clock after the request.
- R3: A request whose entry has its resident flag at 0 gives `rsp_fault`=1, `rsp_pa`=0 and `rsp_dirty`=0. A store to such a page leaves the entry's dirty flag unchanged.
- R4: A request whose entry is resident gives `rsp_fault`=0 and `rsp_pa` = {ppn, `req_va`[OFF_W-1:0]}. The entry is indexed by `req_va`[VA_W-1:OFF_W].
- R5: A store (`req_store`=1) that hits a resident entry sets that entry's dirty flag. `rsp_dirty` reports the entry's dirty flag as it stands after the access, so a store hit always returns 1.
- R6: A load (`req_store`=0) leaves the dirty flag unchanged.
- R7: `kern_mode`=1 selects the kernel map and 0 selects the user map. An entry written with `wr_ctx`=1 is in the kernel map and is invisible to user lookups, and the reverse also holds.
- R8: With `wr_en`=1, the entry at `wr_vpn` in map `wr_ctx` takes {`wr_res`, `wr_dirty`, `wr_ppn`} at the clock edge. A lookup of that entry in the same cycle still sees the old contents.
- R9: When a write and a store hit target the same entry in the same cycle, the written value wins, including its dirty flag.
- R10: In a cycle with `rsp_valid`=0, `rsp_fault`, `rsp_pa` and `rsp_dirty` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_va | input | VA_W | Virtual address |
| req_store | input | 1 | Request is a store |
| kern_mode | input | 1 | 1 selects the kernel map, 0 selects the user map |
| wr_en | input | 1 | Handler entry write |
| wr_ctx | input | 1 | Map written: 1 is kernel, 0 is user |
| wr_vpn | input | VA_W-OFF_W | Virtual page number written |
| wr_ppn | input | PA_W-OFF_W | Physical page number loaded |
| wr_res | input | 1 | Resident flag loaded |
| wr_dirty | input | 1 | Dirty flag loaded |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 1 | Page fault |
| rsp_pa | output | PA_W | Physical address |
| rsp_dirty | output | 1 | Dirty flag of the entry after the access |

## Verification
The hardest cases to reach are the ones where the handler write port and a lookup land on the same entry in the same clock. In one case the write must be invisible to the lookup. In the other, the write must override the dirty flag that a store hit would set. The stimulus creates both cases on purpose. It writes an entry while looking that entry up, and it stores to a dirty-clean resident page while rewriting it. Follow-up loads then bring the resulting flags out through `rsp_dirty`. After that, a long run of random mixed traffic on a narrow set of pages and both contexts makes these collisions recur. A behavioural model checks every response cycle.

// File: rtl/page_map_xlate.sv
module page_map_xlate #(
  parameter int VA_W  = 18,
  parameter int PA_W  = 20,
  parameter int OFF_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [VA_W-1:0]       req_va,
  input  logic                  req_store,
  input  logic                  kern_mode,
  input  logic                  wr_en,
  input  logic                  wr_ctx,
  input  logic [VA_W-OFF_W-1:0] wr_vpn,
  input  logic [PA_W-OFF_W-1:0] wr_ppn,
  input  logic                  wr_res,
  input  logic                  wr_dirty,
  output logic                  rsp_valid,
  output logic                  rsp_fault,
  output logic [PA_W-1:0]       rsp_pa,
  output logic                  rsp_dirty
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int NPAGE = 1 << VPN_W;
  localparam int ENT_W = PPN_W + 2;
  localparam int RES_B = ENT_W - 1;
  localparam int DRT_B = ENT_W - 2;

  logic [ENT_W-1:0] map_q [2][NPAGE];

  logic [VPN_W-1:0] vpn;
  logic [OFF_W-1:0] off;
  logic [ENT_W-1:0] ent;
  logic             hit;

  assign vpn = req_va[VA_W-1:OFF_W];
  assign off = req_va[OFF_W-1:0];
  assign ent = map_q[kern_mode][vpn];
  assign hit = req_valid & ent[RES_B];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++)
        for (int i = 0; i < NPAGE; i++)
          map_q[c][i] <= '0;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_pa    <= '0;
      rsp_dirty <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid & ~ent[RES_B];
      rsp_pa    <= hit ? {ent[PPN_W-1:0], off} : '0;
      rsp_dirty <= hit & (ent[DRT_B] | req_store);
      if (hit && req_store)
        map_q[kern_mode][vpn][DRT_B] <= 1'b1;
      if (wr_en)
        map_q[wr_ctx][wr_vpn] <= {wr_res, wr_dirty, wr_ppn};
    end
  end
endmodule

module page_map_xlate_chk #(
  parameter int VA_W  = 18,
  parameter int PA_W  = 20,
  parameter int OFF_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [VA_W-1:0] req_va,
  input logic            req_store,
  input logic            rsp_valid,
  input logic            rsp_fault,
  input logic [PA_W-1:0] rsp_pa,
  input logic            rsp_dirty
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> rsp_valid); // R2
  AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !rsp_valid); // R2
  AST_FAULT_HAS_NO_PA: assert property (@(posedge clk) disable iff (!rst_n) rsp_fault |-> (rsp_pa == '0 && !rsp_dirty)); // R3
  AST_OFFSET_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_fault || rsp_pa[OFF_W-1:0] == $past(req_va[OFF_W-1:0]))); // R4
  AST_STORE_HIT_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store) |=> (rsp_fault || rsp_dirty)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_fault && rsp_pa == '0 && !rsp_dirty)); // R10
endmodule

bind page_map_xlate page_map_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va), .req_store(req_store),
  .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa), .rsp_dirty(rsp_dirty)
);

// File: tb/page_map_xlate_test.sv
`timescale 1ns/1ps
module page_map_xlate_test;
  localparam int VA_W = 18, PA_W = 20, OFF_W = 12;
  localparam int VPN_W = VA_W - OFF_W, PPN_W = PA_W - OFF_W, NPAGE = 1 << VPN_W;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_store = 0, kern_mode = 0;
  logic [VA_W-1:0] req_va = '0;
  logic wr_en = 0, wr_ctx = 0, wr_res = 0, wr_dirty = 0;
  logic [VPN_W-1:0] wr_vpn = '0;
  logic [PPN_W-1:0] wr_ppn = '0;
  logic rsp_valid, rsp_fault, rsp_dirty;
  logic [PA_W-1:0] rsp_pa;

  page_map_xlate #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va), .req_store(req_store),
    .kern_mode(kern_mode), .wr_en(wr_en), .wr_ctx(wr_ctx), .wr_vpn(wr_vpn), .wr_ppn(wr_ppn),
    .wr_res(wr_res), .wr_dirty(wr_dirty), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_pa(rsp_pa), .rsp_dirty(rsp_dirty));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  bit m_res [2][NPAGE];
  bit m_drt [2][NPAGE];
  int m_ppn [2][NPAGE];
  logic e_v, e_f, e_d;
  logic [PA_W-1:0] e_pa;

  task automatic model_step();
    int c, v;
    if (!rst_n) begin
      for (int a = 0; a < 2; a++)
        for (int i = 0; i < NPAGE; i++) begin m_res[a][i] = 0; m_drt[a][i] = 0; m_ppn[a][i] = 0; end
      e_v = 0; e_f = 0; e_d = 0; e_pa = '0;
      return;
    end
    c = kern_mode ? 1 : 0;
    v = int'(req_va) / (1 << OFF_W);
    e_v = req_valid; e_f = 0; e_d = 0; e_pa = '0;
    if (req_valid) begin
      if (m_res[c][v]) begin
        e_pa = PA_W'(m_ppn[c][v] * (1 << OFF_W) + int'(req_va) % (1 << OFF_W));
        if (req_store) m_drt[c][v] = 1;
        e_d = m_drt[c][v];
      end else e_f = 1;
    end
    if (wr_en) begin
      m_res[wr_ctx][wr_vpn] = wr_res;
      m_drt[wr_ctx][wr_vpn] = wr_dirty;
      m_ppn[wr_ctx][wr_vpn] = int'(wr_ppn);
    end
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    checks++;
    if (rsp_valid !== e_v || rsp_fault !== e_f || rsp_pa !== e_pa || rsp_dirty !== e_d) begin
      errors++;
      $display("FAIL %s: actual v=%b f=%b pa=%h d=%b expected v=%b f=%b pa=%h d=%b",
               tag, rsp_valid, rsp_fault, rsp_pa, rsp_dirty, e_v, e_f, e_pa, e_d);
    end
    req_valid = 0; req_store = 0; wr_en = 0;
  endtask

  task automatic req(input logic km, input int vpn, input int off, input logic st);
    req_valid = 1; kern_mode = km; req_store = st;
    req_va = VA_W'(vpn * (1 << OFF_W) + off);
  endtask

  task automatic wr(input logic ctx, input int vpn, input int ppn, input logic r, input logic d);
    wr_en = 1; wr_ctx = ctx; wr_vpn = VPN_W'(vpn); wr_ppn = PPN_W'(ppn); wr_res = r; wr_dirty = d;
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    req_va = 18'h3f123; req_valid = 1;
    cyc("R1"); cyc("R1");
    @(negedge clk); rst_n = 1;
    // R1 R3: every page starts non-resident in both maps
    req(0, 0, 0, 0); cyc("R1");
    req(1, 63, 5, 0); cyc("R1");
    req(0, 5, 12, 1); cyc("R3");
    cyc("R10");
    // R8: write entries, lookup of same entry in same cycle sees old state
    wr(0, 5, 8'ha3, 1, 0); req(0, 5, 1, 0); cyc("R8");
    wr(1, 5, 8'h11, 1, 0); cyc("R8");
    req(0, 5, 12'h7ff, 0); cyc("R4");
    req(1, 5, 12'hfff, 0); cyc("R7");
    wr(1, 9, 8'h40, 1, 0); cyc("R7");
    req(0, 9, 3, 0); cyc("R7");
    req(1, 9, 3, 0); cyc("R7");
    // R5 R6: store sets dirty, loads keep it
    req(0, 5, 0, 0); cyc("R6");
    req(0, 5, 8, 1); cyc("R5");
    req(0, 5, 16, 0); cyc("R5");
    req(1, 5, 16, 0); cyc("R7");
    req(1, 9, 0, 0); cyc("R6");
    req(1, 9, 0, 0); cyc("R6");
    // R9: handler write wins over store dirty set
    wr(1, 9, 8'h77, 1, 0); req(1, 9, 4, 1); cyc("R9");
    req(1, 9, 4, 0); cyc("R9");
    // R3: clearing resident brings a fault back
    wr(0, 5, 8'h22, 0, 1); cyc("R3");
    req(0, 5, 4, 1); cyc("R3");
    wr(0, 5, 8'h22, 1, 0); cyc("R3");
    req(0, 5, 4, 0); cyc("R3");
    cyc("R2"); cyc("R10");
    // random mixed traffic on a narrow page set
    for (int n = 0; n < 2000; n++) begin
      if ($urandom_range(0, 3) != 0)
        req(1'($urandom_range(0, 1)), $urandom_range(0, 7), $urandom_range(0, 4095), 1'($urandom_range(0, 1)));
      if ($urandom_range(0, 2) == 0)
        wr(1'($urandom_range(0, 1)), $urandom_range(0, 7), $urandom_range(0, 255),
           1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)));
      cyc("R4");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule